// File: doc/BRIEF.md
# Flash Ready/Completion Pin Controller

This block drives the status output of a flash memory model. A two-bit mode code, held in a small configuration register, picks what the pin reports. In level mode the pin mirrors the write engine: it is high when the engine is idle and low while it is busy, so a memory controller can hold off accesses. In the three pulse modes the pin rests high and drops low for a fixed number of clock cycles when a selected operation finishes: an erase, a program, or either one.

The configuration register is written through a one-cycle write strobe with a data byte. Only the two lowest data bits form the mode code, and all higher bits are ignored. A synthesis parameter lists which codes the device supports. A write carrying an unsupported code leaves the mode unchanged and sets both status error flags. A clear input resets those flags. An accepted configuration write also ends any pulse that is in progress. A completion event that arrives during a pulse starts the full pulse width again.

Top module: `rdy_pin_ctrl`

## Requirements
- R1: After the synchronous active-low reset the mode is level (code 0), both error flags are 0, and the pin is high while the engine is idle.
- R2: In level mode (code 0) the pin equals the inverse of `engine_busy` in the same cycle, and completion strobes have no effect on it.
- R3: In mode code 1 an `erase_done` strobe sampled at a clock edge drives the pin low for exactly PULSE_CYCLES cycles, starting right after that edge. `prog_done` and `engine_busy` have no effect on the pin in this mode.
- R4: In mode code 2 only a `prog_done` strobe starts a pulse. `erase_done` is ignored.
- R5: In mode code 3 either strobe starts a pulse.
- R6: A selected completion strobe that arrives while a pulse is active restarts the full PULSE_CYCLES width, counted from that edge.
- R7: Only `cfg_data[1:0]` form the mode code. Bits `cfg_data[7:2]` have no effect.
- R8: A write whose code has a 0 at its position in SUPPORTED_MASK (bit n stands for code n) leaves the mode unchanged and sets `err_flags` to 2'b11. Bit 0 is status bit 4 and bit 1 is status bit 5.
- R9: `err_clear` sets `err_flags` to 0 on the next edge. An unsupported write in the same cycle wins, and the flags stay 2'b11.
- R10: An accepted configuration write ends an active pulse at that edge, and the pin then follows the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| engine_busy | input | 1 | Write engine busy |
| erase_done | input | 1 | One-cycle erase completion strobe |
| prog_done | input | 1 | One-cycle program completion strobe |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_data | input | DATA_W | Configuration data; bits [1:0] form the mode code |
| err_clear | input | 1 | Clears the error flags |
| status_pin | output | 1 | Ready/completion pin (low = busy or pulse) |
| err_flags | output | 2 | Error flags for status bits 5:4 |

## Verification
The bench uses a short pulse width of 6 cycles, so the bounds of every pulse and every restart fall inside a few dozen cycles. It builds two instances fed by the same stimulus. One supports all four codes, which makes the either-event mode reachable. The other has SUPPORTED_MASK = 4'b0111, so code 3 becomes unsupported and the error-flag path and the unchanged mode can be seen on the same writes. Comparing the two instances cycle by cycle also shows that an accepted write cancels a pulse while a rejected write leaves it running.

// File: rtl/pinctl_pkg.sv
// Shared types for the ready/completion pin controller.
// Assumes a two-bit mode code; code values are fixed by the pin behaviour.
package pinctl_pkg;
    localparam int CODE_W = 2;

    typedef enum logic [CODE_W-1:0] {
        PM_LEVEL = 2'b00,
        PM_ERASE = 2'b01,
        PM_PROG  = 2'b10,
        PM_ANY   = 2'b11
    } pin_mode_e;
endpackage

// File: rtl/pin_cfg_reg.sv
// Configuration register: decodes the low two data bits into a mode.
// Rejects codes not listed in SUPPORTED_MASK and raises both error flags.
// Assumes cfg_we is a single-cycle strobe in the clk domain.
module pin_cfg_reg
    import pinctl_pkg::*;
#(
    parameter int           DATA_W         = 8,
    parameter logic [3:0]   SUPPORTED_MASK = 4'b1111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_data,
    input  logic              err_clear,
    output pin_mode_e         mode,
    output logic [1:0]        err,
    output logic              apply
);
    logic [CODE_W-1:0] code;
    logic              code_ok;
    logic              reject;

    // Decode the code field and check it against the supported set.
    always_comb begin
        code    = cfg_data[CODE_W-1:0];
        code_ok = SUPPORTED_MASK[code];
        apply   = cfg_we && code_ok;
        reject  = cfg_we && !code_ok;
    end

    // Hold the current mode; load it only on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= PM_LEVEL;
        else if (apply)
            mode <= pin_mode_e'(code);
    end

    // Error flags: set on a rejected write, which takes priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err <= 2'b00;
        else if (reject)
            err <= 2'b11;
        else if (err_clear)
            err <= 2'b00;
    end
endmodule

// File: rtl/pin_evt_sel.sv
// Completion event selector: passes the strobes that the mode enables.
// Purely combinational; level mode passes nothing.
module pin_evt_sel
    import pinctl_pkg::*;
(
    input  pin_mode_e mode,
    input  logic      erase_done,
    input  logic      prog_done,
    output logic      fire
);
    // Select the strobes that the current mode enables.
    always_comb begin
        unique case (mode)
            PM_ERASE: fire = erase_done;
            PM_PROG:  fire = prog_done;
            PM_ANY:   fire = erase_done || prog_done;
            default:  fire = 1'b0;
        endcase
    end
endmodule

// File: rtl/pin_pulse_timer.sv
// Pulse timer: a down-counter loaded with PULSE_CYCLES on each trigger.
// active stays high while the count is non-zero. cancel wins over load.
module pin_pulse_timer #(
    parameter int PULSE_CYCLES = 50,
    localparam int CNT_W = $clog2(PULSE_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             cancel,
    output logic [CNT_W-1:0] cnt,
    output logic             active
);
    localparam logic [CNT_W-1:0] WIDTH = CNT_W'(PULSE_CYCLES);

    // Count down; reload on a trigger, clear on cancel.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (cancel)
            cnt <= '0;
        else if (load)
            cnt <= WIDTH;
        else if (cnt != '0)
            cnt <= cnt - CNT_W'(1);
    end

    // The pulse is active while any count remains.
    always_comb active = (cnt != '0);
endmodule

// File: rtl/rdy_pin_ctrl.sv
// Top of the ready/completion pin controller.
// Assumes the completion strobes are one cycle wide and the busy input is synchronous to clk.
module rdy_pin_ctrl
    import pinctl_pkg::*;
#(
    parameter int         DATA_W         = 8,
    parameter int         PULSE_CYCLES   = 50,
    parameter logic [3:0] SUPPORTED_MASK = 4'b1111,
    localparam int        CNT_W          = $clog2(PULSE_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              engine_busy,
    input  logic              erase_done,
    input  logic              prog_done,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_data,
    input  logic              err_clear,
    output logic              status_pin,
    output logic [1:0]        err_flags
);
    pin_mode_e        mode;
    logic             apply;
    logic             fire;
    logic [CNT_W-1:0] cnt;
    logic             active;

    pin_cfg_reg #(.DATA_W(DATA_W), .SUPPORTED_MASK(SUPPORTED_MASK)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data),
        .err_clear(err_clear), .mode(mode), .err(err_flags), .apply(apply)
    );

    pin_evt_sel u_sel (
        .mode(mode), .erase_done(erase_done), .prog_done(prog_done), .fire(fire)
    );

    pin_pulse_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(fire), .cancel(apply),
        .cnt(cnt), .active(active)
    );

    // Pin mux: level mode shows idle/busy; pulse modes show the timer.
    always_comb status_pin = (mode == PM_LEVEL) ? !engine_busy : !active;
endmodule

// File: rtl/rdy_pin_ctrl_chk.sv
// Assertion checker for rdy_pin_ctrl, attached to every instance by bind.
module rdy_pin_ctrl_chk
    import pinctl_pkg::*;
#(
    parameter int         DATA_W         = 8,
    parameter int         PULSE_CYCLES   = 50,
    parameter logic [3:0] SUPPORTED_MASK = 4'b1111,
    parameter int         CNT_W          = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              erase_done,
    input logic              prog_done,
    input logic              cfg_we,
    input logic [DATA_W-1:0] cfg_data,
    input logic              err_clear,
    input logic              status_pin,
    input logic [1:0]        err_flags,
    input pin_mode_e         mode,
    input logic              apply,
    input logic              fire,
    input logic [CNT_W-1:0]  cnt
);
    logic bad_wr;
    always_comb bad_wr = cfg_we && !SUPPORTED_MASK[cfg_data[1:0]];

    p_level_no_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_LEVEL) |-> (cnt == '0));
    p_rest_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != PM_LEVEL && cnt == '0) |-> status_pin);
    p_pulse_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != PM_LEVEL && cnt != '0) |-> !status_pin);
    p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0 && !fire && !apply) |=> (cnt == $past(cnt) - CNT_W'(1)));
    p_erase_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_PROG && erase_done && !prog_done) |-> !fire);
    p_either_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_ANY && (erase_done || prog_done)) |-> fire);
    p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !apply) |=> (cnt == CNT_W'(PULSE_CYCLES)));
    p_err_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bad_wr |=> (err_flags == 2'b11));
    p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bad_wr |=> $stable(mode));
    p_err_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clear && !bad_wr) |=> (err_flags == 2'b00));
    p_cancel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> (cnt == '0));
endmodule

bind rdy_pin_ctrl rdy_pin_ctrl_chk #(
    .DATA_W(DATA_W), .PULSE_CYCLES(PULSE_CYCLES),
    .SUPPORTED_MASK(SUPPORTED_MASK), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .erase_done(erase_done), .prog_done(prog_done),
    .cfg_we(cfg_we), .cfg_data(cfg_data), .err_clear(err_clear),
    .status_pin(status_pin), .err_flags(err_flags), .mode(mode),
    .apply(apply), .fire(fire), .cnt(cnt)
);

// File: tb/tb_rdy_pin_ctrl.sv
// Scoreboard bench: drive() applies one cycle of stimulus and queues the expected
// outputs of both instances; the monitor pops and compares after each edge.
module tb_rdy_pin_ctrl;
    localparam int         N      = 6;
    localparam logic [3:0] MASK_A = 4'b1111;
    localparam logic [3:0] MASK_B = 4'b0111;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       busy = 1'b0, er = 1'b0, pr = 1'b0, we = 1'b0, clr = 1'b0;
    logic [7:0] data = 8'h00;
    logic       pin_a, pin_b;
    logic [1:0] err_a, err_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    rdy_pin_ctrl #(.PULSE_CYCLES(N), .SUPPORTED_MASK(MASK_A)) dut (
        .clk(clk), .rst_n(rst_n), .engine_busy(busy), .erase_done(er),
        .prog_done(pr), .cfg_we(we), .cfg_data(data), .err_clear(clr),
        .status_pin(pin_a), .err_flags(err_a)
    );

    rdy_pin_ctrl #(.PULSE_CYCLES(N), .SUPPORTED_MASK(MASK_B)) dut_lim (
        .clk(clk), .rst_n(rst_n), .engine_busy(busy), .erase_done(er),
        .prog_done(pr), .cfg_we(we), .cfg_data(data), .err_clear(clr),
        .status_pin(pin_b), .err_flags(err_b)
    );

    typedef struct {
        logic       pa;
        logic       pb;
        logic [1:0] ea;
        logic [1:0] eb;
        string      tag;
    } item_t;

    item_t q[$];

    // Reference state per instance, written from the requirements.
    int m_mode[2];
    int m_left[2];
    int m_err[2];

    task automatic drive(input logic b, input logic e, input logic p, input logic w,
                         input logic [7:0] d, input logic c, input string tag);
        item_t it;
        logic  pin_x[2];
        @(negedge clk);
        busy = b; er = e; pr = p; we = w; data = d; clr = c;
        for (int k = 0; k < 2; k++) begin
            logic [3:0] msk;
            int  code;
            bit  ok, hit;
            msk  = (k == 0) ? MASK_A : MASK_B;
            code = int'(d[1:0]);
            ok   = msk[code];
            hit  = (m_mode[k] == 1 && e) || (m_mode[k] == 2 && p) ||
                   (m_mode[k] == 3 && (e || p));
            if (w && ok) begin
                m_mode[k] = code;
                m_left[k] = 0;
            end else if (hit)
                m_left[k] = N;
            else if (m_left[k] > 0)
                m_left[k] = m_left[k] - 1;
            if (w && !ok)
                m_err[k] = 3;
            else if (c)
                m_err[k] = 0;
            pin_x[k] = (m_mode[k] == 0) ? !b : (m_left[k] == 0);
        end
        it.pa = pin_x[0]; it.pb = pin_x[1];
        it.ea = 2'(m_err[0]); it.eb = 2'(m_err[1]);
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, tag);
    endtask

    // Monitor: compare both instances one time unit after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if ({pin_a, pin_b, err_a, err_b} !== {it.pa, it.pb, it.ea, it.eb}) begin
                    fails++;
                    $display("FAIL %s: pin a/b=%b/%b err a/b=%b/%b, expected pin %b/%b err %b/%b",
                             it.tag, pin_a, pin_b, err_a, err_b, it.pa, it.pb, it.ea, it.eb);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 2; k++) begin
            m_mode[k] = 0; m_left[k] = 0; m_err[k] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, level mode, idle pin high, flags clear
        idle(2, "R1");
        // R2: level mode follows busy, strobes ignored
        drive(1, 0, 0, 0, 8'h00, 0, "R2");
        drive(1, 1, 0, 0, 8'h00, 0, "R2");
        drive(0, 0, 1, 0, 8'h00, 0, "R2");
        drive(0, 1, 1, 0, 8'h00, 0, "R2");
        idle(1, "R2");
        // R3: erase-only mode, exact width, program strobe and busy ignored
        drive(0, 0, 0, 1, 8'h01, 0, "R3");
        drive(1, 1, 0, 0, 8'h00, 0, "R3");
        idle(8, "R3");
        drive(1, 0, 1, 0, 8'h00, 0, "R3");
        idle(2, "R3");
        // R6: restart during an active pulse
        drive(0, 1, 0, 0, 8'h00, 0, "R6");
        idle(3, "R6");
        drive(0, 1, 0, 0, 8'h00, 0, "R6");
        idle(8, "R6");
        // R10: accepted write cancels a running pulse
        drive(0, 1, 0, 0, 8'h00, 0, "R10");
        idle(2, "R10");
        drive(0, 0, 0, 1, 8'h02, 0, "R10");
        idle(2, "R10");
        // R4: program-only mode
        drive(0, 1, 0, 0, 8'h00, 0, "R4");
        drive(0, 0, 1, 0, 8'h00, 0, "R4");
        idle(7, "R4");
        // R7: reserved bits ignored
        drive(0, 0, 0, 1, 8'hFC, 0, "R7");
        drive(1, 0, 0, 0, 8'h00, 0, "R7");
        drive(0, 0, 0, 1, 8'hA9, 0, "R7");
        drive(0, 1, 0, 0, 8'h00, 0, "R7");
        idle(7, "R7");
        // R5 and R8: code 3 accepted on one instance, rejected on the other
        drive(0, 0, 0, 1, 8'h03, 0, "R8");
        drive(0, 1, 0, 0, 8'h00, 0, "R5");
        idle(7, "R5");
        drive(0, 0, 1, 0, 8'h00, 0, "R5");
        idle(7, "R5");
        // R8: rejected write mid-pulse leaves the pulse running on the limited instance
        drive(0, 1, 0, 0, 8'h00, 0, "R8");
        drive(0, 0, 0, 1, 8'h03, 0, "R8");
        idle(6, "R8");
        // R9: clear, set-over-clear priority, clear again
        drive(0, 0, 0, 0, 8'h00, 1, "R9");
        drive(0, 0, 0, 1, 8'h03, 1, "R9");
        drive(0, 0, 0, 0, 8'h00, 1, "R9");
        idle(2, "R9");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule